// File: doc/BRIEF.md
# Protection Unit Configuration Register Bank

This block is the software-visible configuration store for an eight-region memory protection unit. It sits on a simple single-cycle word bus with a request, a write flag, a byte address, write data, byte strobes and read data. It holds five registers: a fixed identification word, a three-bit control register, a region selector, and a base register and an attribute/size register for each region. The per-region registers are not mapped side by side. Software first picks a region through the selector, then reads or writes that region's base or attributes through two shared windows.

A base write may carry its own region number. When the valid flag in that write is set, the selector is first loaded with the embedded number, and the base is then stored into the newly chosen region within the same bus cycle. All stored settings leave the block as flat per-region vectors, together with the control bits, for a separate permission checker. Read data is combinational from the current state. A write takes effect at the clock edge that ends the request cycle.

Top module: `prot_cfg_regs`

## Requirements
- R1: Reading offset 0x90 returns 0x00000800, which reports eight regions in bits 15:8 and zero in every other bit. A write to this offset changes nothing.
- R2: The control register at offset 0x94 holds the enable bit in bit 0, the fault-handler enable in bit 1 and the privileged background enable in bit 2. A full-word write (all four strobes set) loads these bits, bits 31:3 read as zero, and the three bits drive `ctl_enable`, `ctl_fault_en` and `ctl_bg_priv`.
- R3: The selector at offset 0x98 stores bits 7:0 of a full-word write and reads them back in bits 7:0, with zeros above.
- R4: A full-word write to offset 0x9C with bit 4 set first loads the selector with bits 3:0 (upper selector bits cleared). The base is then stored into the region that the new selector value names.
- R5: A read of offset 0x9C returns the selected region's stored base in bits 31:5, zero in bit 4, and selector bits 3:0 in bits 3:0. Only bits 31:5 of a base write are kept.
- R6: The attribute word at offset 0xA0 keeps bit 28 (execute-never), bits 26:24 (access permission), bits 21:19 (type extension), bits 18:16 (shareable, cacheable, bufferable), bits 15:8 (sub-region disables), bits 5:1 (size code) and bit 0 (region enable). All other bits read as zero.
- R7: The attribute word is written per halfword. Bits 15:0 update only when strobes 1:0 are both set, and bits 31:16 only when strobes 3:2 are both set. A single-byte strobe pattern leaves the word unchanged.
- R8: While the selector holds 8 or more, base and attribute writes change no region, and reads of offsets 0x9C and 0xA0 return zero. This includes a base write whose override names 8 to 15.
- R9: After reset, control, selector, all bases and all attribute words are zero. Every region enable output is therefore low.
- R10: The export ports show every region's stored base, size, sub-region disables, permission, execute-never, type extension and S/C/B bits, and its enable. The values appear in the cycle after the write that sets them and change only after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, bit n for bits 8n+7:8n |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| ctl_enable | output | 1 | Protection enable |
| ctl_fault_en | output | 1 | Protection stays active in top-priority fault handlers |
| ctl_bg_priv | output | 1 | Default map acts as background for privileged access |
| rgn_en | output | NUM_REGIONS | Region enable per region |
| rgn_base | output | NUM_REGIONS*27 | Base bits 31:5 per region |
| rgn_size | output | NUM_REGIONS*5 | Size code per region |
| rgn_srd | output | NUM_REGIONS*8 | Sub-region disable bits per region |
| rgn_ap | output | NUM_REGIONS*3 | Access permission code per region |
| rgn_xn | output | NUM_REGIONS | Execute-never per region |
| rgn_tex | output | NUM_REGIONS*3 | Type extension per region |
| rgn_scb | output | NUM_REGIONS*3 | Shareable, cacheable, bufferable per region |

## Verification
The indirect access path is driven with selector values inside the region range, above it, and set through the base-write override. The first pair shows whether out-of-range selection really blocks storage. The last shows whether the override lands before the store. Attribute writes use full-word, lower-half, upper-half and single-byte strobes, which separates halfword merging from whole-word replacement and from ignored partial lanes. A long random mix of writes to every offset, including unmapped ones, is followed by a sweep over every region. The sweep compares the indirect reads and the flat export vectors, so a value stored into the wrong region shows up even when the selected region reads correctly.

// File: rtl/prot_cfg_pkg.sv
`timescale 1ns/1ps
package prot_cfg_pkg;

    localparam int BASE_LSB = 5;
    localparam int BASE_W   = 32 - BASE_LSB;
    localparam int SEL_W    = 8;

    localparam logic [7:0] OFS_TYPE = 8'h90;
    localparam logic [7:0] OFS_CTL  = 8'h94;
    localparam logic [7:0] OFS_SEL  = 8'h98;
    localparam logic [7:0] OFS_BASE = 8'h9C;
    localparam logic [7:0] OFS_ATTR = 8'hA0;

    // Attribute bits that are kept: 28, 26:24, 21:16, 15:8, 5:0
    localparam logic [31:0] ATTR_KEEP = 32'h173F_FF3F;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_TYPE,
        RD_CTL,
        RD_SEL,
        RD_BASE,
        RD_ATTR
    } rd_sel_e;

    typedef struct packed {
        logic    wr_ctl;
        logic    wr_sel;
        logic    wr_base;
        logic    wr_attr_lo;
        logic    wr_attr_hi;
        rd_sel_e rd;
    } dec_t;

    typedef struct packed {
        logic [2:0]       ctl;
        logic [SEL_W-1:0] sel;
    } bank_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [31:0]       attr;
    } rgn_t;

endpackage

// File: rtl/prot_cfg_decode.sv
`timescale 1ns/1ps
module prot_cfg_decode
    import prot_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output dec_t              dec
);

    logic hit_type, hit_ctl, hit_sel, hit_base, hit_attr;
    logic do_wr, do_rd, full_word;

    always_comb begin
        hit_type  = (addr == ADDR_W'(OFS_TYPE));
        hit_ctl   = (addr == ADDR_W'(OFS_CTL));
        hit_sel   = (addr == ADDR_W'(OFS_SEL));
        hit_base  = (addr == ADDR_W'(OFS_BASE));
        hit_attr  = (addr == ADDR_W'(OFS_ATTR));
        do_wr     = req && wr;
        do_rd     = req && !wr;
        full_word = (be == 4'hF);

        dec.wr_ctl     = do_wr && hit_ctl  && full_word;
        dec.wr_sel     = do_wr && hit_sel  && full_word;
        dec.wr_base    = do_wr && hit_base && full_word;
        dec.wr_attr_lo = do_wr && hit_attr && (be[1:0] == 2'b11);
        dec.wr_attr_hi = do_wr && hit_attr && (be[3:2] == 2'b11);

        dec.rd = RD_NONE;
        if (do_rd) begin
            if      (hit_type) dec.rd = RD_TYPE;
            else if (hit_ctl)  dec.rd = RD_CTL;
            else if (hit_sel)  dec.rd = RD_SEL;
            else if (hit_base) dec.rd = RD_BASE;
            else if (hit_attr) dec.rd = RD_ATTR;
        end
    end

endmodule

// File: rtl/prot_cfg_region.sv
`timescale 1ns/1ps
module prot_cfg_region
    import prot_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_base,
    input  logic        we_lo,
    input  logic        we_hi,
    input  logic [31:0] wdata,
    output rgn_t        rgn
);

    rgn_t rgn_d, rgn_q;

    always_comb begin
        rgn_d = rgn_q;
        if (we_base) rgn_d.base = wdata[31:BASE_LSB];
        if (we_lo)   rgn_d.attr[15:0]  = wdata[15:0]  & ATTR_KEEP[15:0];
        if (we_hi)   rgn_d.attr[31:16] = wdata[31:16] & ATTR_KEEP[31:16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgn_q <= '0;
        else        rgn_q <= rgn_d;
    end

    assign rgn = rgn_q;

endmodule

// File: rtl/prot_cfg_regs.sv
`timescale 1ns/1ps
module prot_cfg_regs
    import prot_cfg_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic [3:0]                bus_be,
    output logic [31:0]               bus_rdata,
    output logic                      ctl_enable,
    output logic                      ctl_fault_en,
    output logic                      ctl_bg_priv,
    output logic [NUM_REGIONS-1:0]    rgn_en,
    output logic [NUM_REGIONS*27-1:0] rgn_base,
    output logic [NUM_REGIONS*5-1:0]  rgn_size,
    output logic [NUM_REGIONS*8-1:0]  rgn_srd,
    output logic [NUM_REGIONS*3-1:0]  rgn_ap,
    output logic [NUM_REGIONS-1:0]    rgn_xn,
    output logic [NUM_REGIONS*3-1:0]  rgn_tex,
    output logic [NUM_REGIONS*3-1:0]  rgn_scb
);

    localparam int          IDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam logic [31:0] TYPE_WORD = 32'(NUM_REGIONS) << 8;

    dec_t  dec;
    bank_t bank_d, bank_q;
    rgn_t  rgn_q [NUM_REGIONS];

    logic             tgt_ok, cur_ok;
    logic [IDX_W-1:0] tgt_idx, cur_idx;

    prot_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req  (bus_req),
        .wr   (bus_wr),
        .addr (bus_addr),
        .be   (bus_be),
        .dec  (dec)
    );

    // Next state of control and selector; a base write carrying the
    // valid flag redirects the selector before the store below uses it.
    always_comb begin
        bank_d = bank_q;
        if (dec.wr_ctl) bank_d.ctl = bus_wdata[2:0];
        if (dec.wr_sel) bank_d.sel = bus_wdata[SEL_W-1:0];
        if (dec.wr_base && bus_wdata[4]) bank_d.sel = {4'b0, bus_wdata[3:0]};

        tgt_ok  = (bank_d.sel < SEL_W'(NUM_REGIONS));
        tgt_idx = bank_d.sel[IDX_W-1:0];
        cur_ok  = (bank_q.sel < SEL_W'(NUM_REGIONS));
        cur_idx = bank_q.sel[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_rgn
        logic hit;
        assign hit = tgt_ok && (tgt_idx == IDX_W'(gi));

        prot_cfg_region u_region (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_base (dec.wr_base    && hit),
            .we_lo   (dec.wr_attr_lo && hit),
            .we_hi   (dec.wr_attr_hi && hit),
            .wdata   (bus_wdata),
            .rgn     (rgn_q[gi])
        );

        assign rgn_en[gi]          = rgn_q[gi].attr[0];
        assign rgn_base[gi*27+:27] = rgn_q[gi].base;
        assign rgn_size[gi*5+:5]   = rgn_q[gi].attr[5:1];
        assign rgn_srd[gi*8+:8]    = rgn_q[gi].attr[15:8];
        assign rgn_ap[gi*3+:3]     = rgn_q[gi].attr[26:24];
        assign rgn_xn[gi]          = rgn_q[gi].attr[28];
        assign rgn_tex[gi*3+:3]    = rgn_q[gi].attr[21:19];
        assign rgn_scb[gi*3+:3]    = rgn_q[gi].attr[18:16];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (dec.rd)
            RD_TYPE: bus_rdata = TYPE_WORD;
            RD_CTL:  bus_rdata = {29'b0, bank_q.ctl};
            RD_SEL:  bus_rdata = {{(32-SEL_W){1'b0}}, bank_q.sel};
            RD_BASE: if (cur_ok) bus_rdata = {rgn_q[cur_idx].base, 1'b0, bank_q.sel[3:0]};
            RD_ATTR: if (cur_ok) bus_rdata = rgn_q[cur_idx].attr;
            default: bus_rdata = '0;
        endcase
    end

    assign ctl_enable   = bank_q.ctl[0];
    assign ctl_fault_en = bank_q.ctl[1];
    assign ctl_bg_priv  = bank_q.ctl[2];

endmodule

// File: rtl/prot_cfg_checker.sv
`timescale 1ns/1ps
module prot_cfg_checker #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_req,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_wdata,
    input logic [3:0]             bus_be,
    input logic [31:0]            bus_rdata,
    input logic [2:0]             ctl_bits,
    input logic [NUM_REGIONS-1:0] rgn_en,
    input logic [7:0]             sel_q
);

    logic rd_type, rd_ctl, rd_base, wr_any, wr_ctl, wr_base_v, wr_attr;

    always_comb begin
        rd_type   = bus_req && !bus_wr && (bus_addr == ADDR_W'(8'h90));
        rd_ctl    = bus_req && !bus_wr && (bus_addr == ADDR_W'(8'h94));
        rd_base   = bus_req && !bus_wr && (bus_addr == ADDR_W'(8'h9C));
        wr_any    = bus_req && bus_wr;
        wr_ctl    = wr_any && (bus_addr == ADDR_W'(8'h94));
        wr_base_v = wr_any && (bus_addr == ADDR_W'(8'h9C)) && (bus_be == 4'hF) && bus_wdata[4];
        wr_attr   = wr_any && (bus_addr == ADDR_W'(8'hA0));
    end

    assert_type_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_type |-> (bus_rdata == (32'(NUM_REGIONS) << 8)));

    assert_ctl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> (bus_rdata[31:3] == 29'b0));

    assert_ctl_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_bits) |-> $past(wr_ctl));

    assert_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base_v |=> (sel_q == {4'b0, $past(bus_wdata[3:0])}));

    assert_base_valid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_base |-> (bus_rdata[4] == 1'b0));

    assert_high_sel_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_attr && (sel_q >= 8'(NUM_REGIONS))) |=> $stable(rgn_en));

    assert_en_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rgn_en) |-> $past(wr_any));

endmodule

bind prot_cfg_regs prot_cfg_checker #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .ctl_bits  ({ctl_bg_priv, ctl_fault_en, ctl_enable}),
    .rgn_en    (rgn_en),
    .sel_q     (bank_q.sel)
);

// File: tb/prot_cfg_regs_bench.sv
`timescale 1ns/1ps
module prot_cfg_regs_bench;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_rdata;
    logic          ctl_enable, ctl_fault_en, ctl_bg_priv;
    logic [N-1:0]  rgn_en, rgn_xn;
    logic [N*27-1:0] rgn_base;
    logic [N*5-1:0]  rgn_size;
    logic [N*8-1:0]  rgn_srd;
    logic [N*3-1:0]  rgn_ap, rgn_tex, rgn_scb;

    prot_cfg_regs #(.NUM_REGIONS(N), .ADDR_W(8)) u_prot_cfg_regs (
        .clk, .rst_n, .bus_req, .bus_wr, .bus_addr, .bus_wdata, .bus_be, .bus_rdata,
        .ctl_enable, .ctl_fault_en, .ctl_bg_priv, .rgn_en, .rgn_base, .rgn_size,
        .rgn_srd, .rgn_ap, .rgn_xn, .rgn_tex, .rgn_scb
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [2:0]  m_ctl = '0;
    logic [7:0]  m_sel = '0;
    logic [31:0] m_base [N];
    logic [31:0] m_attr [N];

    function automatic void model_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        case (a)
            8'h94: if (be == 4'hF) m_ctl = d[2:0];
            8'h98: if (be == 4'hF) m_sel = d[7:0];
            8'h9C: if (be == 4'hF) begin
                if (d[4]) m_sel = {4'b0, d[3:0]};
                if (m_sel < N) m_base[m_sel[2:0]] = d & 32'hFFFF_FFE0;
            end
            8'hA0: if (m_sel < N) begin
                if (be[1:0] == 2'b11) m_attr[m_sel[2:0]][15:0]  = d[15:0]  & 16'hFF3F;
                if (be[3:2] == 2'b11) m_attr[m_sel[2:0]][31:16] = d[31:16] & 16'h173F;
            end
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h90: return 32'h0000_0800;
            8'h94: return {29'b0, m_ctl};
            8'h98: return {24'b0, m_sel};
            8'h9C: return (m_sel < N) ? {m_base[m_sel[2:0]][31:5], 1'b0, m_sel[3:0]} : 32'h0;
            8'hA0: return (m_sel < N) ? m_attr[m_sel[2:0]] : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        model_write(a, d, be);
    endtask

    task automatic rd(string tag, logic [7:0] a);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_req = 0;
    endtask

    task automatic check_exports(string tag);
        check({tag, " ctl"}, {29'b0, ctl_bg_priv, ctl_fault_en, ctl_enable}, {29'b0, m_ctl});
        for (int r = 0; r < N; r++) begin
            check({tag, " en"},   32'(rgn_en[r]),           32'(m_attr[r][0]));
            check({tag, " base"}, 32'(rgn_base[r*27+:27]),  32'(m_base[r][31:5]));
            check({tag, " size"}, 32'(rgn_size[r*5+:5]),    32'(m_attr[r][5:1]));
            check({tag, " srd"},  32'(rgn_srd[r*8+:8]),     32'(m_attr[r][15:8]));
            check({tag, " ap"},   32'(rgn_ap[r*3+:3]),      32'(m_attr[r][26:24]));
            check({tag, " xn"},   32'(rgn_xn[r]),           32'(m_attr[r][28]));
            check({tag, " tex"},  32'(rgn_tex[r*3+:3]),     32'(m_attr[r][21:19]));
            check({tag, " scb"},  32'(rgn_scb[r*3+:3]),     32'(m_attr[r][18:16]));
        end
    endtask

    function automatic logic [7:0] pick_addr(int k);
        case (k % 7)
            0: return 8'h90; 1: return 8'h94; 2: return 8'h98;
            3: return 8'h9C; 4: return 8'hA0; 5: return 8'hA0;
            default: return 8'h8C;
        endcase
    endfunction

    function automatic logic [3:0] pick_be(int k);
        case (k % 5)
            0: return 4'h3; 1: return 4'hC; 2: return 4'h1;
            default: return 4'hF;
        endcase
    endfunction

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd2024);
        for (int r = 0; r < N; r++) begin m_base[r] = '0; m_attr[r] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9 reset state, R1 type word
        check_exports("R9 reset");
        rd("R9 ctl reset", 8'h94);
        rd("R9 sel reset", 8'h98);
        rd("R1 type", 8'h90);
        wr(8'h90, 32'hFFFF_FFFF, 4'hF);
        rd("R1 type after write", 8'h90);

        // R2 control
        wr(8'h94, 32'hFFFF_FFFF, 4'hF);
        rd("R2 ctl", 8'h94);
        check_exports("R2 outputs");
        wr(8'h94, 32'h0000_0002, 4'h1);
        rd("R2 ctl partial ignored", 8'h94);

        // R3 selector, R8 out-of-range selection
        wr(8'h98, 32'h1234_56AB, 4'hF);
        rd("R3 sel", 8'h98);
        wr(8'hA0, 32'hFFFF_FFFF, 4'hF);
        wr(8'h9C, 32'hFFFF_FFE0, 4'hF);
        rd("R8 base read high sel", 8'h9C);
        rd("R8 attr read high sel", 8'hA0);
        check_exports("R8 no store");

        // R4 override, R5 readback
        wr(8'h9C, 32'hABCD_EF15, 4'hF);
        rd("R4 sel after override", 8'h98);
        rd("R5 base readback", 8'h9C);
        check_exports("R4 stored region 5");
        wr(8'h9C, 32'h5555_551C, 4'hF);
        rd("R8 override to 12", 8'h98);
        check_exports("R8 override blocked");

        // R6 masking, R7 halfword lanes
        wr(8'h98, 32'h0000_0002, 4'hF);
        wr(8'hA0, 32'hFFFF_FFFF, 4'hF);
        rd("R6 attr mask", 8'hA0);
        wr(8'hA0, 32'h0000_0000, 4'h3);
        rd("R7 lower half", 8'hA0);
        wr(8'hA0, 32'h0000_FFFF, 4'hC);
        rd("R7 upper half", 8'hA0);
        wr(8'hA0, 32'hFFFF_FFFF, 4'h1);
        rd("R7 byte ignored", 8'hA0);
        check_exports("R10 after attr");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = pick_addr($urandom);
            d = $urandom;
            if (a == 8'h98 && ($urandom % 4 != 0)) d = d % 10;
            wr(a, d, pick_be($urandom));
            rd("R10 random read", pick_addr($urandom));
        end

        // Sweep every region
        for (int r = 0; r < N; r++) begin
            wr(8'h98, 32'(r), 4'hF);
            rd("R5 sweep base", 8'h9C);
            rd("R6 sweep attr", 8'hA0);
        end
        check_exports("R10 sweep");

        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule